// File: doc/BRIEF.md
# Programmable Interval Timer

A memory-mapped timer for a bus clock domain. Software loads a divide code, a compare value and the interrupt behaviour through a simple register port, then sets a run bit. A prescaler turns the bus clock into ticks, and an up-counter advances on each tick. When the counter equals the compare value on a tick, the block can latch an interrupt status that drives the interrupt line. It can also return the counter to zero, which gives periodic operation.

With zero-clear off, the block gives one-shot events, or it serves as a plain readable time base that wraps at the counter width. Stopping the counter can also clear it, but only after the block has once run with the clear-on-stop bit set. The usual bring-up is therefore a start with that bit set, followed by a stop.

Register map (word index on `reg_addr`): 0 control, 1 status, 2 compare, 3 divide code, 4 interrupt mode, 5 live count (read only). Every other address reads zero.

Top module: `interval_timer`

## Requirements
- R1: After reset the compare register reads all ones, the control, status, divide, interrupt-mode and count registers read zero, `irq` is low, and unmapped addresses read zero.
- R2: With the divide-enable bit (control bit 2) set, the count advances once every `2 << D` clocks, where D is the divide register (bits DIV_W-1:0). With that bit clear, the count advances on every clock.
- R3: The count changes only while the run bit (control bit 0) is set, and only on a tick. A stopped counter holds its value unless R4 applies.
- R4: While run is clear and clear-on-stop (control bit 1) is set, the count is forced to zero. This happens only once the block is armed. It arms on the first cycle after reset in which run and clear-on-stop are both set.
- R5: With zero-clear (interrupt-mode bit 1) set, a tick on which the count equals compare sets the count to zero. The interval is then compare+1 ticks.
- R6: With zero-clear clear, the count keeps counting past compare and wraps from all ones to zero.
- R7: With interrupt enable (interrupt-mode bit 0) set, a tick on which the count equals compare sets status bit 0. `irq` equals status bit 0.
- R8: Writing the status register with bit 0 at 0 clears the status, and writing bit 0 at 1 leaves it unchanged. A match in the same cycle as a clearing write leaves the status set.
- R9: Reading address 5 returns the live count, and reading it does not change it.
- R10: Control reads back with run at bit 0, clear-on-stop at bit 1, divide-enable at bit 2 and the mode field at bits 5:4. The compare, divide and interrupt-mode registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from address |
| irq | output | 1 | Interrupt, high while status is pending |

## Verification
The assertions check the cycle-level rules on every clock. These are the return to zero on a zero-clear match, the forced clear of an armed stopped counter, and the hold of the count between ticks. They also cover the status being set by an enabled match and dropped by a clearing write, with the match winning a tie. Only the bench scenarios can show the tick rate for each divide code and the one-shot and wrap behaviour across a whole interval. They also show the arming rule, where a clear-on-stop before the first armed start has no effect.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;

  localparam int A_CTRL  = 0;
  localparam int A_STAT  = 1;
  localparam int A_CMP   = 2;
  localparam int A_DIV   = 3;
  localparam int A_IMODE = 4;
  localparam int A_COUNT = 5;

  typedef struct packed {
    logic [1:0] mode;
    logic       div_en;
    logic       clr_on_stop;
    logic       run;
  } ctrl_t;

  // Clocks per tick: 2 << code when dividing, else one.
  function automatic logic [31:0] tick_period(input logic [31:0] code, input logic div_en);
    return div_en ? (32'd2 << code) : 32'd1;
  endfunction

endpackage

// File: rtl/it_prescaler.sv
module it_prescaler
  import interval_timer_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             div_en,
  input  logic [DIV_W-1:0] code,
  output logic             tick
);
  localparam int PW = (1 << DIV_W) + 2;

  logic [PW-1:0] presc_q;
  logic [PW-1:0] limit;
  logic [31:0]   period;

  always_comb begin
    period = tick_period(32'(code), div_en);
    limit  = PW'(period - 32'd1);
  end

  // >= keeps ticking sane if the code shrinks while running
  assign tick = run && (presc_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            presc_q <= '0;
    else if (!run || tick) presc_q <= '0;
    else                   presc_q <= presc_q + 1'b1;
  end

endmodule

// File: rtl/it_counter.sv
module it_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr_on_stop,
  input  logic             tick,
  input  logic             zero_clr,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] count,
  output logic             match_ev
);
  logic armed_q;
  logic stop_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_q | (run & clr_on_stop);
  end

  assign stop_clr = !run && clr_on_stop && armed_q;
  assign match_ev = tick && (count == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (stop_clr)             count <= '0;
    else if (match_ev && zero_clr) count <= '0;
    else if (tick)                 count <= count + 1'b1;
  end

  assert_zero_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && zero_clr) |=> (count == '0));

  assert_stop_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_clr |=> (count == '0));

  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !stop_clr) |=> $stable(count));

endmodule

// File: rtl/it_regs.sv
module it_regs
  import interval_timer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              match_ev,
  input  logic [CNT_W-1:0]  count,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  cmp,
  output logic [DIV_W-1:0]  div_code,
  output logic              irq_en,
  output logic              zero_clr,
  output logic [DATA_W-1:0] rdata,
  output logic              status
);
  logic wr_ctrl, wr_stat, wr_cmp, wr_div, wr_imode;
  logic set_ev, clr_ev;

  assign wr_ctrl  = we && (addr == ADDR_W'(A_CTRL));
  assign wr_stat  = we && (addr == ADDR_W'(A_STAT));
  assign wr_cmp   = we && (addr == ADDR_W'(A_CMP));
  assign wr_div   = we && (addr == ADDR_W'(A_DIV));
  assign wr_imode = we && (addr == ADDR_W'(A_IMODE));

  assign set_ev = match_ev && irq_en;
  assign clr_ev = wr_stat && !wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      cmp      <= '1;
      div_code <= '0;
      irq_en   <= 1'b0;
      zero_clr <= 1'b0;
    end else begin
      if (wr_ctrl)  ctrl     <= '{mode: wdata[5:4], div_en: wdata[2],
                                  clr_on_stop: wdata[1], run: wdata[0]};
      if (wr_cmp)   cmp      <= wdata[CNT_W-1:0];
      if (wr_div)   div_code <= wdata[DIV_W-1:0];
      if (wr_imode) begin
        irq_en   <= wdata[0];
        zero_clr <= wdata[1];
      end
    end
  end

  // hardware set outranks a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status <= 1'b0;
    else if (set_ev) status <= 1'b1;
    else if (clr_ev) status <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(A_CTRL):  rdata = DATA_W'({ctrl.mode, 1'b0, ctrl.div_en, ctrl.clr_on_stop, ctrl.run});
      ADDR_W'(A_STAT):  rdata = DATA_W'(status);
      ADDR_W'(A_CMP):   rdata = DATA_W'(cmp);
      ADDR_W'(A_DIV):   rdata = DATA_W'(div_code);
      ADDR_W'(A_IMODE): rdata = DATA_W'({zero_clr, irq_en});
      ADDR_W'(A_COUNT): rdata = DATA_W'(count);
      default:          rdata = '0;
    endcase
  end

  assert_match_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> status);

  assert_clear_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> !status);

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import interval_timer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cmp;
  logic [CNT_W-1:0] count;
  logic [DIV_W-1:0] div_code;
  logic             irq_en, zero_clr, tick, match_ev, status;

  it_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .match_ev(match_ev), .count(count), .ctrl(ctrl), .cmp(cmp),
    .div_code(div_code), .irq_en(irq_en), .zero_clr(zero_clr),
    .rdata(reg_rdata), .status(status)
  );

  it_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .div_en(ctrl.div_en),
    .code(div_code), .tick(tick)
  );

  it_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .clr_on_stop(ctrl.clr_on_stop),
    .tick(tick), .zero_clr(zero_clr), .cmp(cmp), .count(count), .match_ev(match_ev)
  );

  assign irq = status;

endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq;

  int n_checks = 0;
  int n_fail   = 0;

  interval_timer u_interval_timer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  // columns: divide code, compare, zero-clear, irq enable, divide enable, clocks
  localparam int NV = 7;
  localparam int VEC [NV][6] = '{
    '{0, 15,    1, 1, 1, 100},
    '{1, 20,    0, 1, 1, 100},
    '{2, 40,    0, 1, 1, 200},
    '{0, 15,    1, 0, 1, 64},
    '{3, 30,    1, 1, 0, 75},
    '{7, 15,    0, 1, 1, 1000},
    '{0, 65535, 0, 1, 0, 65540}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_addr  = ADDR_W'(a);
    reg_wdata = d;
    reg_we    = 1'b1;
    @(posedge clk);
    #1 reg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = ADDR_W'(a);
    #1 d = reg_rdata;
  endtask

  function automatic int unsigned model_ticks(int d, int den, int n);
    int unsigned p;
    p = den != 0 ? (1 << (d + 1)) : 1;
    return n / p;
  endfunction

  function automatic int unsigned model_count(int d, int cmpv, int z, int den, int n);
    int unsigned t;
    t = model_ticks(d, den, n);
    if (z != 0) return t % (cmpv + 1);
    return t % (1 << CNT_W);
  endfunction

  initial begin
    int unsigned wd;
    for (wd = 0; wd < 190000; wd++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); check("R1 ctrl", v, 0);
    rd(1, v); check("R1 stat", v, 0);
    rd(2, v); check("R1 cmp", v, 32'hFFFF);
    rd(3, v); check("R1 div", v, 0);
    rd(4, v); check("R1 imode", v, 0);
    rd(5, v); check("R1 count", v, 0);
    rd(7, v); check("R1 unmapped", v, 0);
    check("R1 irq", irq, 0);

    // R4: clear-on-stop has no effect before arming
    wr(0, 32'h1);
    repeat (9) @(negedge clk);
    wr(0, 32'h2);
    repeat (3) @(negedge clk);
    rd(5, v); check("R4 unarmed stop holds", v, 10);
    rd(5, v2); check("R9 read no side effect", v2, 10);
    repeat (4) @(negedge clk);
    rd(5, v); check("R3 stopped holds", v, 10);
    wr(0, 32'h3);
    repeat (2) @(negedge clk);
    wr(0, 32'h2);
    repeat (2) @(negedge clk);
    rd(5, v); check("R4 armed stop clears", v, 0);
    wr(0, 32'h32);
    rd(0, v); check("R10 ctrl readback", v, 32'h32);
    wr(0, 32'h2);

    // table of scenarios: R2 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      wr(0, 32'h2);
      wr(1, 32'h0);
      wr(3, 32'(VEC[i][0]));
      wr(2, 32'(VEC[i][1]));
      wr(4, 32'((VEC[i][2] << 1) | VEC[i][3]));
      rd(2, v); check("R10 cmp readback", v, 32'(VEC[i][1]));
      wr(0, 32'(3 | (VEC[i][4] << 2)));
      repeat (VEC[i][5]) @(negedge clk);
      rd(5, v);
      check("R2/R5/R6 count", v,
            model_count(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][4], VEC[i][5]));
      check("R7 irq", irq,
            32'((VEC[i][3] != 0) &&
                (model_ticks(VEC[i][0], VEC[i][4], VEC[i][5]) >= 32'(VEC[i][1] + 1))));
    end

    // R8: match beats a same-cycle clear; write of 1 keeps status
    wr(0, 32'h2);
    wr(1, 32'h0);
    wr(2, 32'd15);
    wr(4, 32'h3);
    wr(0, 32'h3);
    repeat (31) @(negedge clk);
    wr(1, 32'h0);
    check("R8 match wins over clear", irq, 1);
    rd(5, v); check("R5 wrapped to zero at match", v, 0);
    wr(1, 32'h1);
    check("R8 write one keeps status", irq, 1);
    wr(1, 32'h0);
    check("R8 write zero clears", irq, 0);
    rd(1, v); check("R8 stat reads zero", v, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule